// File: doc/BRIEF.md
# Sub-Word Register Window Bridge

This block sits between a little-endian host I/O window of 128 bytes and three internal register targets that accept only aligned 32-bit word accesses. The targets are a bank of core registers, a bank of DMA registers and one bus-control register. The host may read or write 1, 2 or 4 bytes at any offset. The bridge turns every host access into word-aligned target accesses and returns read data already shifted and trimmed to the requested width.

A write that covers the whole aligned word goes straight to the target. Any narrower or misaligned write is turned into a read-modify-write. The bridge first reads the current word from the target region. It then overlays the new bytes onto that word and writes the full word back. Offsets that map to no target read as zero. Writes to such offsets never reach a target.

The control is a five-state machine:
- `ST_IDLE` accepts a request and chooses the path.
- `ST_FETCH` reads the current word for a merge.
- `ST_STORE` writes the word.
- `ST_LOAD` reads the word for the host.
- `ST_DONE` returns the response.

The named transitions are:
- IDLE→FETCH for a mapped merge write.
- IDLE→STORE for a mapped full aligned write.
- IDLE→LOAD for a mapped read.
- IDLE→DONE for any unmapped access.
- FETCH→STORE, STORE→DONE and LOAD→DONE.
- DONE→IDLE.

Top module: `reg_window_bridge`

## Requirements
- R1: Word offsets 0x00–0x3F select the core bank with index addr[5:2]. Word offsets 0x40–0x5F select the DMA bank with index (addr−0x40)>>2. Word offset 0x70 selects the bus-control register with index 0. Strobe bit 0 is core, bit 1 is DMA and bit 2 is bus-control.
- R2: Size code 0 means one byte, code 1 means two bytes, and codes 2 and 3 mean four bytes. Written bytes come from h_wdata starting at its lowest byte. They are placed in lanes starting at addr[1:0], and bytes that would fall past lane 3 are dropped.
- R3: A write to a mapped word that is narrower than 4 bytes or has addr[1:0]≠0 takes two target cycles. The first cycle asserts the read strobe and the second asserts the write strobe, both on the same region and index. Unwritten bytes keep their current value.
- R4: A 4-byte write with addr[1:0]=0 to a mapped word asserts only the write strobe, once, with h_wdata unchanged.
- R5: Read data is the target word shifted right by 8×addr[1:0] and masked to 8×size bytes. The unused high bits are zero.
- R6: A read of an unmapped offset returns zero and asserts no strobe. Unmapped offsets are 0x60–0x6F, 0x71–0x7F and all offsets at or above 0x74 apart from the exact offset 0x70.
- R7: A write to any unmapped word (0x60–0x6F or 0x74–0x7F) asserts no strobe and changes no target.
- R8: A write anywhere in 0x70–0x73 updates the bus-control register. A read reaches that register only at exactly 0x70.
- R9: h_ready is a one-cycle pulse. Counting clock edges from the accepting edge, it rises after 2 edges for a read or full write, 3 for a merge write and 1 for an unmapped access. h_rdata is zero on write responses.
- R10: After reset, h_ready, all strobes and h_rdata are zero.
- R11: At most one target strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host request, held until h_ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 7 | Host byte offset in the window |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Host write data, lowest byte first |
| h_rdata | output | 32 | Aligned, width-masked read data |
| h_ready | output | 1 | Response pulse |
| t_idx | output | 4 | Word index within the selected region |
| t_rd | output | 3 | One-hot target read strobe per region |
| t_wr | output | 3 | One-hot target write strobe per region |
| t_wdata | output | 32 | Full word written to the target |
| core_rdata | input | 32 | Core bank word at t_idx |
| dma_rdata | input | 32 | DMA bank word at t_idx |
| bctl_rdata | input | 32 | Bus-control register value |

## Verification
The bench builds the bridge with its default map: 16 core words, 8 DMA words at 0x40 and the control word at 0x70. With this map, every region boundary and both unmapped gaps lie inside the 7-bit window. The last DMA word, the last core byte and the aliased bus-control bytes can all be reached directly. The bench stands in for the three targets as register arrays, counts read and write strobes per transaction, and measures the response latency. Every merge path can then be checked against its expected strobe order and cycle count, as well as against its data.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    typedef enum logic [1:0] {
        RGN_CORE = 2'd0,
        RGN_DMA  = 2'd1,
        RGN_BCTL = 2'd2,
        RGN_NONE = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } sz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_LOAD,
        ST_DONE
    } st_e;

    function automatic logic [2:0] rgn_strobe(input rgn_e r);
        logic [2:0] s;
        unique case (r)
            RGN_CORE: s = 3'b001;
            RGN_DMA:  s = 3'b010;
            RGN_BCTL: s = 3'b100;
            default:  s = 3'b000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rwb_decode.sv
module rwb_decode
    import rwb_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int IDX_W      = 4,
    parameter int CORE_WORDS = 16,
    parameter int DMA_BASE   = 64,
    parameter int DMA_WORDS  = 8,
    parameter int BCTL_OFS   = 112
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rd_rgn,
    output rgn_e              wr_rgn,
    output logic [IDX_W-1:0]  idx
);

    localparam int CORE_END = CORE_WORDS * 4;
    localparam int DMA_END  = DMA_BASE + DMA_WORDS * 4;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] dma_off;

    always_comb begin
        waddr   = {addr[ADDR_W-1:2], 2'b00};
        dma_off = waddr - ADDR_W'(DMA_BASE);
        wr_rgn  = RGN_NONE;
        idx     = '0;
        if (int'(waddr) < CORE_END) begin
            wr_rgn = RGN_CORE;
            idx    = waddr[IDX_W+1:2];
        end else if (int'(waddr) < DMA_END) begin
            wr_rgn = RGN_DMA;
            idx    = dma_off[IDX_W+1:2];
        end else if (int'(waddr) == BCTL_OFS) begin
            wr_rgn = RGN_BCTL;
        end
        // reads see the control word only at its exact offset
        rd_rgn = wr_rgn;
        if (wr_rgn == RGN_BCTL && addr[1:0] != 2'b00) begin
            rd_rgn = RGN_NONE;
        end
    end

endmodule

// File: rtl/rwb_lanes.sv
module rwb_lanes
    import rwb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        lane,
    input  sz_e               size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rd_aligned
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  nb;
    logic [LANES-1:0]  wlanes;
    logic [DATA_W-1:0] wbits;
    logic [DATA_W-1:0] rbits;
    logic [DATA_W-1:0] shifted;
    logic [4:0]        sh;

    always_comb begin
        unique case (size)
            SZ_BYTE: nb = LANES'(1);
            SZ_HALF: nb = LANES'(3);
            default: nb = '1;
        endcase
        sh     = {lane, 3'b000};
        wlanes = nb << lane;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wbits[8*g +: 8] = {8{wlanes[g]}};
        assign rbits[8*g +: 8] = {8{nb[g]}};
    end

    always_comb begin
        shifted    = wdata << sh;
        merged     = (cur & ~wbits) | (shifted & wbits);
        rd_aligned = (src >> sh) & rbits;
    end

endmodule

// File: rtl/rwb_ctrl.sv
module rwb_ctrl
    import rwb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic [DATA_W-1:0] h_wdata,
    input  rgn_e              rd_rgn,
    input  rgn_e              wr_rgn,
    input  logic [DATA_W-1:0] merged,
    input  logic [DATA_W-1:0] rd_aligned,
    output logic [ADDR_W-1:0] dec_addr,
    output sz_e               size_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [2:0]        t_rd,
    output logic [2:0]        t_wr,
    output logic [DATA_W-1:0] t_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata
);

    st_e               state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic              narrow_q;
    logic              narrow_in;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] rdata_q;

    // the live request is decoded while idle, the latched one afterwards
    assign dec_addr  = (state_q == ST_IDLE) ? h_addr : addr_q;
    assign narrow_in = (h_size == SZ_BYTE) || (h_size == SZ_HALF) || (h_addr[1:0] != 2'b00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (h_req) begin
                    if (h_we && wr_rgn != RGN_NONE) begin
                        state_d = narrow_in ? ST_FETCH : ST_STORE;
                    end else if (!h_we && rd_rgn != RGN_NONE) begin
                        state_d = ST_LOAD;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_FETCH: state_d = ST_STORE;
            ST_STORE: state_d = ST_DONE;
            ST_LOAD:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            size_q   <= SZ_BYTE;
            we_q     <= 1'b0;
            narrow_q <= 1'b0;
            wdata_q  <= '0;
            word_q   <= '0;
            rdata_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && h_req) begin
                addr_q   <= h_addr;
                size_q   <= sz_e'(h_size);
                we_q     <= h_we;
                narrow_q <= narrow_in;
                wdata_q  <= h_wdata;
                rdata_q  <= '0;
            end
            if (state_q == ST_FETCH) begin
                word_q <= merged;
            end
            if (state_q == ST_LOAD) begin
                rdata_q <= rd_aligned;
            end
        end
    end

    always_comb begin
        t_rd    = 3'b000;
        t_wr    = 3'b000;
        t_wdata = narrow_q ? word_q : wdata_q;
        h_ready = 1'b0;
        unique case (state_q)
            ST_FETCH: t_rd    = rgn_strobe(wr_rgn);
            ST_LOAD:  t_rd    = rgn_strobe(rd_rgn);
            ST_STORE: t_wr    = rgn_strobe(wr_rgn);
            ST_DONE:  h_ready = 1'b1;
            default:  ;
        endcase
    end

    assign h_rdata = rdata_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({t_rd, t_wr}) <= 1);                                   // R11
    AST_MERGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (t_wr != 3'b000 && narrow_q) |-> $past(t_rd) == t_wr);            // R3
    AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (t_wr != 3'b000 && !narrow_q) |-> $past(t_rd) == 3'b000);         // R4
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);                                            // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready && !we_q && $past(t_rd) == 3'b000) |-> h_rdata == '0);   // R6
    AST_WRITE_RESP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready && we_q) |-> h_rdata == '0);                             // R9

endmodule

// File: rtl/reg_window_bridge.sv
module reg_window_bridge
    import rwb_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int CORE_WORDS = 16,
    parameter int DMA_BASE   = 64,
    parameter int DMA_WORDS  = 8,
    parameter int BCTL_OFS   = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_ready,
    output logic [IDX_W-1:0]  t_idx,
    output logic [2:0]        t_rd,
    output logic [2:0]        t_wr,
    output logic [DATA_W-1:0] t_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic [DATA_W-1:0] bctl_rdata
);

    logic [ADDR_W-1:0] dec_addr;
    rgn_e              rd_rgn, wr_rgn;
    sz_e               size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] merged, rd_aligned;
    logic [DATA_W-1:0] cur_word, src_word;

    rwb_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_WORDS(CORE_WORDS),
        .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS), .BCTL_OFS(BCTL_OFS)
    ) i_decode (
        .addr(dec_addr), .rd_rgn(rd_rgn), .wr_rgn(wr_rgn), .idx(t_idx)
    );

    // current-value lookup for merging and the source word for reads
    always_comb begin
        unique case (wr_rgn)
            RGN_CORE: cur_word = core_rdata;
            RGN_DMA:  cur_word = dma_rdata;
            RGN_BCTL: cur_word = bctl_rdata;
            default:  cur_word = '0;
        endcase
        unique case (rd_rgn)
            RGN_CORE: src_word = core_rdata;
            RGN_DMA:  src_word = dma_rdata;
            RGN_BCTL: src_word = bctl_rdata;
            default:  src_word = '0;
        endcase
    end

    rwb_lanes #(.DATA_W(DATA_W)) i_lanes (
        .lane(dec_addr[1:0]), .size(size_q), .wdata(wdata_q),
        .cur(cur_word), .src(src_word),
        .merged(merged), .rd_aligned(rd_aligned)
    );

    rwb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_size(h_size),
        .h_wdata(h_wdata), .rd_rgn(rd_rgn), .wr_rgn(wr_rgn),
        .merged(merged), .rd_aligned(rd_aligned),
        .dec_addr(dec_addr), .size_q(size_q), .wdata_q(wdata_q),
        .t_rd(t_rd), .t_wr(t_wr), .t_wdata(t_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata)
    );

    AST_DMA_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (t_rd[1] || t_wr[1]) |-> int'(t_idx) < DMA_WORDS);                // R1
    AST_BCTL_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (t_rd[2] || t_wr[2]) |-> t_idx == '0);                            // R1

endmodule

// File: tb/test_reg_window_bridge.sv
module test_reg_window_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    typedef struct packed {
        logic        we;
        logic [6:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [1:0]  n_rd;
        logic [1:0]  n_wr;
        logic [7:0]  tag;
    } vec_t;

    // we, addr, size, wdata, expected rdata, read strobes, write strobes, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b1, 7'h04, 2'd2, 32'h11223344, 32'h00000000, 2'd0, 2'd1, 8'd4},  // R4 full write
        '{1'b0, 7'h04, 2'd2, 32'h0,        32'h11223344, 2'd1, 2'd0, 8'd1},  // R1
        '{1'b1, 7'h05, 2'd0, 32'h000000AA, 32'h00000000, 2'd1, 2'd1, 8'd3},  // R3 byte merge
        '{1'b0, 7'h04, 2'd2, 32'h0,        32'h1122AA44, 2'd1, 2'd0, 8'd3},  // R3
        '{1'b1, 7'h06, 2'd1, 32'h0000BBCC, 32'h00000000, 2'd1, 2'd1, 8'd2},  // R2 half at lane 2
        '{1'b0, 7'h07, 2'd0, 32'h0,        32'h000000BB, 2'd1, 2'd0, 8'd5},  // R5
        '{1'b0, 7'h05, 2'd1, 32'h0,        32'h0000CCAA, 2'd1, 2'd0, 8'd5},  // R5
        '{1'b1, 7'h0B, 2'd2, 32'hDEADBEEF, 32'h00000000, 2'd1, 2'd1, 8'd2},  // R2 truncated word
        '{1'b0, 7'h08, 2'd2, 32'h0,        32'hEF000000, 2'd1, 2'd0, 8'd2},  // R2
        '{1'b1, 7'h44, 2'd2, 32'hCAFEF00D, 32'h00000000, 2'd0, 2'd1, 8'd1},  // R1 DMA
        '{1'b0, 7'h46, 2'd2, 32'h0,        32'h0000CAFE, 2'd1, 2'd0, 8'd5},  // R5 shifted word
        '{1'b1, 7'h5C, 2'd1, 32'h00001234, 32'h00000000, 2'd1, 2'd1, 8'd3},  // R3 last DMA word
        '{1'b0, 7'h5C, 2'd2, 32'h0,        32'h00001234, 2'd1, 2'd0, 8'd1},  // R1
        '{1'b1, 7'h72, 2'd0, 32'h0000005A, 32'h00000000, 2'd1, 2'd1, 8'd8},  // R8 alias write
        '{1'b0, 7'h70, 2'd2, 32'h0,        32'h005A0000, 2'd1, 2'd0, 8'd8},  // R8
        '{1'b0, 7'h72, 2'd0, 32'h0,        32'h00000000, 2'd0, 2'd0, 8'd8},  // R8 read off 0x70
        '{1'b1, 7'h64, 2'd2, 32'hFFFFFFFF, 32'h00000000, 2'd0, 2'd0, 8'd7},  // R7
        '{1'b0, 7'h64, 2'd2, 32'h0,        32'h00000000, 2'd0, 2'd0, 8'd6},  // R6
        '{1'b1, 7'h7C, 2'd2, 32'h00000001, 32'h00000000, 2'd0, 2'd0, 8'd7},  // R7
        '{1'b0, 7'h70, 2'd2, 32'h0,        32'h005A0000, 2'd1, 2'd0, 8'd7},  // R7 unchanged
        '{1'b1, 7'h61, 2'd0, 32'h00000033, 32'h00000000, 2'd0, 2'd0, 8'd7},  // R7 narrow unmapped
        '{1'b1, 7'h3F, 2'd0, 32'h00000077, 32'h00000000, 2'd1, 2'd1, 8'd3},  // R3 last core byte
        '{1'b0, 7'h3E, 2'd1, 32'h0,        32'h00007700, 2'd1, 2'd0, 8'd5},  // R5
        '{1'b1, 7'h10, 2'd3, 32'h01020304, 32'h00000000, 2'd0, 2'd1, 8'd2},  // R2 code 3 = word
        '{1'b0, 7'h10, 2'd3, 32'h0,        32'h01020304, 2'd1, 2'd0, 8'd2},  // R2
        '{1'b0, 7'h11, 2'd0, 32'h0,        32'h00000003, 2'd1, 2'd0, 8'd5},  // R5
        '{1'b0, 7'h4C, 2'd2, 32'h0,        32'h00000000, 2'd1, 2'd0, 8'd1}   // R1 untouched DMA word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [6:0]  h_addr = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic [3:0]  t_idx;
    logic [2:0]  t_rd, t_wr;
    logic [31:0] t_wdata;
    logic [31:0] core_rdata, dma_rdata, bctl_rdata;

    logic [31:0] core_m [16];
    logic [31:0] dma_m [8];
    logic [31:0] bctl_m;
    int          n_rd, n_wr, n_multi;
    int          tests = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_window_bridge i_reg_window_bridge (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we),
        .h_addr(h_addr), .h_size(h_size), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_ready(h_ready), .t_idx(t_idx),
        .t_rd(t_rd), .t_wr(t_wr), .t_wdata(t_wdata),
        .core_rdata(core_rdata), .dma_rdata(dma_rdata), .bctl_rdata(bctl_rdata)
    );

    assign core_rdata = core_m[t_idx];
    assign dma_rdata  = dma_m[t_idx[2:0]];
    assign bctl_rdata = bctl_m;

    // bench-side register targets and strobe counters
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) core_m[i] <= '0;
            for (int i = 0; i < 8; i++) dma_m[i] <= '0;
            bctl_m  <= '0;
            n_rd    <= 0;
            n_wr    <= 0;
            n_multi <= 0;
        end else begin
            if (t_wr[0]) core_m[t_idx] <= t_wdata;
            if (t_wr[1]) dma_m[t_idx[2:0]] <= t_wdata;
            if (t_wr[2]) bctl_m <= t_wdata;
            if (t_rd != 3'b000) n_rd <= n_rd + 1;
            if (t_wr != 3'b000) n_wr <= n_wr + 1;
            if ($countones({t_rd, t_wr}) > 1) n_multi <= n_multi + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int rd0, wr0, lat;
        logic [31:0] got;
        string tg;
        tg = $sformatf("R%0d", v.tag);
        @(negedge clk);
        h_req = 1'b1; h_we = v.we; h_addr = v.addr; h_size = v.size; h_wdata = v.wdata;
        rd0 = n_rd; wr0 = n_wr; lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!h_ready && lat < 10);
        got = h_rdata;
        h_req = 1'b0;
        check(got == v.exp, tg, got, v.exp);
        check(n_rd - rd0 == int'(v.n_rd), "R3 read strobes", 32'(n_rd - rd0), 32'(v.n_rd));
        check(n_wr - wr0 == int'(v.n_wr), "R4 write strobes", 32'(n_wr - wr0), 32'(v.n_wr));
        check(lat == 1 + int'(v.n_rd) + int'(v.n_wr), "R9 latency", 32'(lat),
              32'(1 + int'(v.n_rd) + int'(v.n_wr)));
        @(negedge clk);
        check(h_ready == 1'b0, "R9 pulse", 32'(h_ready), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(h_ready == 1'b0, "R10 ready", 32'(h_ready), 32'd0);
        check(t_rd == 3'b000 && t_wr == 3'b000, "R10 strobes", {26'd0, t_rd, t_wr}, 32'd0);
        check(h_rdata == 32'd0, "R10 rdata", h_rdata, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            run_vec(VEC[k]);
        end
        // R7 target state after dropped writes: only core 1, 2, 4, 15 and DMA 1, 7 changed
        check(dma_m[0] == 32'd0 && dma_m[6] == 32'd0, "R7 dma untouched", dma_m[6], 32'd0);
        check(core_m[1] == 32'hBBCCAA44, "R3 core word", core_m[1], 32'hBBCCAA44);
        check(core_m[15] == 32'h77000000, "R2 lane 3", core_m[15], 32'h77000000);
        check(n_multi == 0, "R11 strobe overlap", 32'(n_multi), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule